// File: doc/BRIEF.md
# Debug Breakpoint Match Unit

This unit sits beside the execute stage of a small processor core and watches for debug events. It holds four slot address registers, one control word that selects the enable, kind and span of each slot, and one status word that records which slots matched. Every cycle it compares the current instruction address against slots configured for execution. It also compares the core's data access against slots configured as write-only or read/write watchpoints.

When an enabled slot matches, the status word is rewritten and a debug request pulse is raised one cycle later. The match vector in the status word includes disabled slots whose condition held, but the vector is only committed when an enabled slot hit or when an update is forced. Forced updates come from a dedicated input or from a single-step event, which also sets the step flag. A task-switch event drops every local enable and keeps the global ones. Software reaches all registers through a small indexed port.

Top module: `dbg_match_unit`

## Requirements
- R1: After reset the four slot address registers read 0, the status word reads 0xFFFF0FF0 and the control word reads 0x00000400; the request output is low.
- R2: Register index 0..3 selects slot address 0..3, index 6 the status word, index 7 the control word, and indices 4 and 5 read 0 and ignore writes. Reads are combinational and force the fixed-one bits high (status 0xFFFF0FF0, control 0x00000400). A write is used by comparisons from the next cycle on.
- R3: In the control word, slot i has a local enable at bit 2i and a global enable at bit 2i+1, and it counts as enabled if either is set. Its kind is in bits [17+4i:16+4i] and its length code in bits [19+4i:18+4i].
- R4: An execute slot (kind 0) matches when pc_valid is high and the instruction address equals the slot address.
- R5: A watch slot covers the range given by its length code (0: 1 byte, 1: 2 bytes, 2: 8 bytes, 3: 4 bytes), aligned down to that length. A data access of acc_size (0: 1, 1: 2, 2: 4, 3: 8 bytes) matches if any of its bytes falls in that range. Kind 1 matches writes only, kind 3 matches reads and writes, and kind 2 never matches.
- R6: In a commit, status bits [3:0] are replaced by the vector of matched slots, disabled ones included. A commit happens only if an enabled slot matched, force_upd is high or step_evt is high. Otherwise the status word is unchanged.
- R7: dbg_req is high in the cycle after a cycle in which at least one enabled slot matched, and low otherwise.
- R8: step_evt forces a commit and then sets status bit 14. By itself it raises no request.
- R9: Status bits 13 and 15 are changed only by a register write.
- R10: On task_sw_evt, if any local enable bit (mask 0x55) is set, all local enable bits are cleared. Global enables and all other control bits are kept.
- R11: A register write to the status or control word in the same cycle as an event takes priority over that event's update of the same register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register index for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_idx |
| pc | input | ADDR_W | Current instruction address |
| pc_valid | input | 1 | Instruction address is valid this cycle |
| acc_valid | input | 1 | A data access happens this cycle |
| acc_addr | input | ADDR_W | Data access start address |
| acc_size | input | 2 | Data access size code |
| acc_write | input | 1 | Data access is a write (else a read) |
| force_upd | input | 1 | Force commit of the match vector |
| step_evt | input | 1 | Single-step event |
| task_sw_evt | input | 1 | Task-switch event |
| dbg_req | output | 1 | Debug exception request |

## Verification
The assertions check the invariant parts every cycle. They check that the fixed-one bits show on every status and control read, and that the task-switch event leaves no local enable while the global ones stay stable. They also check that a step always leaves bit 14 set, that bits 13 and 15 move only on a write, and that a request never comes without a nonzero match vector. Only the bench scenarios can show the address arithmetic. That covers range alignment, the overlap at both range edges, read versus write qualification, recording of disabled hits without commit, the one-cycle delay of register writes, and the priority of writes over events.

// File: rtl/dbg_match_pkg.sv
package dbg_match_pkg;

  localparam int unsigned NSLOT  = 4;
  localparam int unsigned DATA_W = 32;

  typedef enum logic [1:0] {
    KIND_EXEC  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_IO    = 2'd2,
    KIND_RW    = 2'd3
  } slot_kind_e;

  localparam logic [DATA_W-1:0] STAT_ONES  = 32'hFFFF_0FF0;
  localparam logic [DATA_W-1:0] CTRL_ONES  = 32'h0000_0400;
  localparam logic [DATA_W-1:0] LOCAL_MASK = 32'h0000_0055;
  localparam int unsigned STAT_STEP_BIT = 14;

  localparam logic [2:0] IDX_STATUS = 3'd6;
  localparam logic [2:0] IDX_CTRL   = 3'd7;

  localparam int unsigned KIND_LSB = 16;
  localparam int unsigned LEN_LSB  = 18;
  localparam int unsigned SLOT_STRIDE = 4;

  // Watch span in bytes for a slot length code.
  function automatic logic [3:0] span_bytes(input logic [1:0] code);
    case (code)
      2'd0:    span_bytes = 4'd1;
      2'd1:    span_bytes = 4'd2;
      2'd2:    span_bytes = 4'd8;
      default: span_bytes = 4'd4;
    endcase
  endfunction

endpackage

// File: rtl/dbg_slot_cmp.sv
module dbg_slot_cmp
  import dbg_match_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] base,
  input  slot_kind_e        kind,
  input  logic [1:0]        len_code,
  input  logic [ADDR_W-1:0] pc,
  input  logic              pc_valid,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_size,
  input  logic              acc_write,
  output logic              hit
);

  localparam int unsigned XW = ADDR_W + 1;

  logic [XW-1:0] w_len, w_lo, w_hi, a_lo, a_hi;
  logic          overlap;
  logic          qualify;

  always_comb begin
    w_len   = XW'(span_bytes(len_code));
    w_lo    = {1'b0, base} & ~(w_len - XW'(1));
    w_hi    = w_lo + w_len;
    a_lo    = {1'b0, acc_addr};
    a_hi    = a_lo + (XW'(1) << acc_size);
    overlap = (a_lo < w_hi) && (w_lo < a_hi);
    case (kind)
      KIND_WRITE: qualify = acc_valid && acc_write;
      KIND_RW:    qualify = acc_valid;
      default:    qualify = 1'b0;
    endcase
    if (kind == KIND_EXEC) hit = pc_valid && (pc == base);
    else                   hit = qualify && overlap;
  end

endmodule

// File: rtl/dbg_reg_bank.sv
module dbg_reg_bank
  import dbg_match_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [2:0]                   wr_idx,
  input  logic [DATA_W-1:0]            wdata,
  input  logic                         task_sw,
  output logic [NSLOT-1:0][ADDR_W-1:0] slot_q,
  output logic [DATA_W-1:0]            ctrl_q
);

  logic [DATA_W-1:0] ctrl_d;
  logic              ctrl_en;
  logic              ctrl_wr;

  genvar gi;
  generate
    for (gi = 0; gi < NSLOT; gi++) begin : g_slot
      logic slot_en;
      assign slot_en = wr_en && (wr_idx == 3'(gi));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       slot_q[gi] <= '0;
        else if (slot_en) slot_q[gi] <= wdata[ADDR_W-1:0];
      end
    end
  endgenerate

  always_comb begin
    ctrl_wr = wr_en && (wr_idx == IDX_CTRL);
    ctrl_d  = ctrl_q;
    ctrl_en = 1'b0;
    if (ctrl_wr) begin
      ctrl_d  = wdata;
      ctrl_en = 1'b1;
    end else if (task_sw && |(ctrl_q & LOCAL_MASK)) begin
      ctrl_d  = ctrl_q & ~LOCAL_MASK;
      ctrl_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= CTRL_ONES;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  // R10: task switch removes every local enable
  a_r10_locals_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (task_sw && !ctrl_wr) |=> ((ctrl_q & LOCAL_MASK) == '0));

  // R10: global enables survive a task switch
  a_r10_globals_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (task_sw && !ctrl_wr) |=> ((ctrl_q & ~LOCAL_MASK) == ($past(ctrl_q) & ~LOCAL_MASK)));

endmodule

// File: rtl/dbg_status_unit.sv
module dbg_status_unit
  import dbg_match_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stat_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NSLOT-1:0]  hit_vec,
  input  logic [NSLOT-1:0]  en_vec,
  input  logic              force_upd,
  input  logic              step_evt,
  output logic [DATA_W-1:0] stat_q,
  output logic              dbg_req
);

  logic [DATA_W-1:0] stat_d;
  logic              stat_en;
  logic              en_hit;
  logic              commit;

  always_comb begin
    en_hit  = |(hit_vec & en_vec);
    commit  = en_hit || force_upd || step_evt;
    stat_d  = stat_q;
    stat_en = 1'b0;
    if (stat_wr) begin
      stat_d  = wdata;
      stat_en = 1'b1;
    end else if (commit) begin
      stat_d = {stat_q[DATA_W-1:NSLOT], hit_vec};
      if (step_evt) stat_d[STAT_STEP_BIT] = 1'b1;
      stat_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= STAT_ONES;
    else if (stat_en) stat_q <= stat_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dbg_req <= 1'b0;
    else        dbg_req <= en_hit;
  end

  // R8: a step always leaves the step flag set
  a_r8_step_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && !stat_wr) |=> stat_q[STAT_STEP_BIT]);

  // R9: access and task flags move only through a register write
  a_r9_flags_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr |=> ($stable(stat_q[13]) && $stable(stat_q[15])));

  // R7: a request is always backed by a recorded match
  a_r7_req_has_match: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_req && !$past(stat_wr)) |-> (stat_q[NSLOT-1:0] != '0));

endmodule

// File: rtl/dbg_match_unit.sv
module dbg_match_unit
  import dbg_match_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [2:0]        reg_idx,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [ADDR_W-1:0] pc,
  input  logic              pc_valid,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_size,
  input  logic              acc_write,
  input  logic              force_upd,
  input  logic              step_evt,
  input  logic              task_sw_evt,
  output logic              dbg_req
);

  logic [NSLOT-1:0][ADDR_W-1:0] slot_q;
  logic [DATA_W-1:0]            ctrl_q;
  logic [DATA_W-1:0]            stat_q;
  logic [NSLOT-1:0]             hit_vec;
  logic [NSLOT-1:0]             en_vec;

  dbg_reg_bank #(.ADDR_W(ADDR_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr_en),
    .wr_idx  (reg_idx),
    .wdata   (reg_wdata),
    .task_sw (task_sw_evt),
    .slot_q  (slot_q),
    .ctrl_q  (ctrl_q)
  );

  genvar gi;
  generate
    for (gi = 0; gi < NSLOT; gi++) begin : g_cmp
      assign en_vec[gi] = |ctrl_q[2*gi +: 2];
      dbg_slot_cmp #(.ADDR_W(ADDR_W)) u_cmp (
        .base      (slot_q[gi]),
        .kind      (slot_kind_e'(ctrl_q[KIND_LSB + SLOT_STRIDE*gi +: 2])),
        .len_code  (ctrl_q[LEN_LSB + SLOT_STRIDE*gi +: 2]),
        .pc        (pc),
        .pc_valid  (pc_valid),
        .acc_valid (acc_valid),
        .acc_addr  (acc_addr),
        .acc_size  (acc_size),
        .acc_write (acc_write),
        .hit       (hit_vec[gi])
      );
    end
  endgenerate

  dbg_status_unit u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .stat_wr   (reg_wr_en && (reg_idx == IDX_STATUS)),
    .wdata     (reg_wdata),
    .hit_vec   (hit_vec),
    .en_vec    (en_vec),
    .force_upd (force_upd),
    .step_evt  (step_evt),
    .stat_q    (stat_q),
    .dbg_req   (dbg_req)
  );

  always_comb begin
    case (reg_idx)
      3'd0, 3'd1, 3'd2, 3'd3: reg_rdata = DATA_W'(slot_q[reg_idx[1:0]]);
      IDX_STATUS:             reg_rdata = stat_q | STAT_ONES;
      IDX_CTRL:               reg_rdata = ctrl_q | CTRL_ONES;
      default:                reg_rdata = '0;
    endcase
  end

  // R2: fixed-one bits show on every status read
  a_r2_stat_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_idx == IDX_STATUS) |-> ((reg_rdata & STAT_ONES) == STAT_ONES));

  // R2: fixed-one bit shows on every control read
  a_r2_ctrl_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_idx == IDX_CTRL) |-> ((reg_rdata & CTRL_ONES) == CTRL_ONES));

endmodule

// File: tb/dbg_match_unit_tb.sv
module dbg_match_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr_en = 0;
  logic [2:0]  reg_idx = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic [31:0] pc = 0;
  logic        pc_valid = 0;
  logic        acc_valid = 0;
  logic [31:0] acc_addr = 0;
  logic [1:0]  acc_size = 0;
  logic        acc_write = 0;
  logic        force_upd = 0;
  logic        step_evt = 0;
  logic        task_sw_evt = 0;
  logic        dbg_req;

  int n_checks = 0;
  int n_errors = 0;

  typedef struct { logic req; string tag; } exp_item_t;
  exp_item_t sb_q[$];

  always #2 clk = ~clk;

  dbg_match_unit #(.ADDR_W(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pc(pc), .pc_valid(pc_valid),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_size(acc_size),
    .acc_write(acc_write), .force_upd(force_upd), .step_evt(step_evt),
    .task_sw_evt(task_sw_evt), .dbg_req(dbg_req)
  );

  // Monitor: compare the request pulse after each driven edge
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_item_t it;
      it = sb_q.pop_front();
      n_checks++;
      if (dbg_req !== it.req) begin
        n_errors++;
        $display("FAIL %s dbg_req actual=%0b expected=%0b", it.tag, dbg_req, it.req);
      end
    end
  end

  task automatic idle_inputs();
    reg_wr_en = 0; pc_valid = 0; acc_valid = 0; acc_write = 0;
    force_upd = 0; step_evt = 0; task_sw_evt = 0;
  endtask

  // Driver: one stimulus cycle, expected request pushed to the scoreboard
  task automatic drive(input logic [31:0] pc_i, input logic pcv,
                       input logic av, input logic [31:0] aa, input logic [1:0] asz,
                       input logic aw, input logic fu, input logic st, input logic ts,
                       input logic we, input logic [2:0] widx, input logic [31:0] wd,
                       input logic exp_req, input string tag);
    exp_item_t it;
    @(negedge clk);
    pc = pc_i; pc_valid = pcv; acc_valid = av; acc_addr = aa; acc_size = asz;
    acc_write = aw; force_upd = fu; step_evt = st; task_sw_evt = ts;
    reg_wr_en = we; reg_idx = widx; reg_wdata = wd;
    it.req = exp_req; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] d, input string tag);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, idx, d, 1'b0, tag);
  endtask

  task automatic exec(input logic [31:0] a, input logic exp_req, input string tag);
    drive(a, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, exp_req, tag);
  endtask

  task automatic data(input logic [31:0] a, input logic [1:0] sz, input logic w,
                      input logic exp_req, input string tag);
    drive(0, 0, 1, a, sz, w, 0, 0, 0, 0, 0, 0, exp_req, tag);
  endtask

  task automatic rd(input logic [2:0] idx, input logic [31:0] exp_v, input string tag);
    @(negedge clk);
    reg_idx = idx;
    #1;
    n_checks++;
    if (reg_rdata !== exp_v) begin
      n_errors++;
      $display("FAIL %s reg[%0d] actual=%08h expected=%08h", tag, idx, reg_rdata, exp_v);
    end
  endtask

  initial begin
    #400000;
    n_errors++;
    $display("FAIL watchdog run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    rd(3'd0, 32'h0, "R1 slot0 reset");
    rd(3'd6, 32'hFFFF0FF0, "R1 status reset");
    rd(3'd7, 32'h00000400, "R1 control reset");
    n_checks++;
    if (dbg_req !== 1'b0) begin
      n_errors++;
      $display("FAIL R1 dbg_req actual=%0b expected=0", dbg_req);
    end

    wr(3'd0, 32'h1000, "R2 wr slot0");
    wr(3'd1, 32'h2000, "R2 wr slot1");
    wr(3'd2, 32'h3000, "R2 wr slot2");
    wr(3'd3, 32'h4005, "R2 wr slot3");
    wr(3'd4, 32'hDEAD, "R2 wr idx4");
    rd(3'd4, 32'h0, "R2 idx4 reads zero");
    // slot0 local exec, slot1 exec disabled, slot2 global write len4, slot3 local rw len8
    wr(3'd7, 32'hBD000461, "R3 wr control");
    rd(3'd7, 32'hBD000461, "R3 control readback");

    exec(32'h1000, 1'b1, "R4 exec hit slot0");
    rd(3'd6, 32'hFFFF0FF1, "R6 status slot0");
    exec(32'h2000, 1'b0, "R6 disabled exec no req");
    rd(3'd6, 32'hFFFF0FF1, "R6 no commit on disabled hit");
    drive(32'h2000, 1, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 1'b0, "R6 forced update");
    rd(3'd6, 32'hFFFF0FF2, "R6 disabled hit recorded on force");

    data(32'h3002, 2'd0, 1'b0, 1'b0, "R5 read ignored by write slot");
    rd(3'd6, 32'hFFFF0FF2, "R5 status after ignored read");
    data(32'h3003, 2'd1, 1'b1, 1'b1, "R5 write hit slot2");
    rd(3'd6, 32'hFFFF0FF4, "R6 status slot2");
    data(32'h3004, 2'd0, 1'b1, 1'b0, "R5 write past range end");
    data(32'h2FFF, 2'd1, 1'b1, 1'b1, "R5 write overlapping range start");
    data(32'h4007, 2'd0, 1'b0, 1'b1, "R5 read hit aligned len8");
    rd(3'd6, 32'hFFFF0FF8, "R6 status slot3");
    data(32'h4000, 2'd2, 1'b1, 1'b1, "R5 write hit rw slot");
    data(32'h4008, 2'd3, 1'b0, 1'b0, "R5 read past len8 range");
    drive(32'h1000, 1, 1, 32'h3000, 2'd0, 1, 0, 0, 0, 0, 0, 0, 1'b1, "R6 two slots at once");
    rd(3'd6, 32'hFFFF0FF5, "R6 two-slot vector");

    drive(32'h1100, 1, 0, 0, 0, 0, 0, 0, 0, 1, 3'd0, 32'h1100, 1'b0, "R2 write not yet used");
    exec(32'h1100, 1'b1, "R2 write used next cycle");
    rd(3'd6, 32'hFFFF0FF1, "R6 status after moved slot0");

    drive(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 1'b0, "R8 step no req");
    rd(3'd6, 32'hFFFF4FF0, "R8 step flag and cleared vector");
    drive(32'h1100, 1, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 1'b1, "R8 step with hit");
    rd(3'd6, 32'hFFFF4FF1, "R8 step with hit status");

    wr(3'd6, 32'h0000A000, "R9 wr status flags");
    rd(3'd6, 32'hFFFFAFF0, "R9 flags readback");
    exec(32'h1100, 1'b1, "R9 hit with flags set");
    rd(3'd6, 32'hFFFFAFF1, "R9 flags kept by match");
    drive(32'h1100, 1, 0, 0, 0, 0, 0, 0, 0, 1, 3'd6, 32'h0, 1'b1, "R11 status write vs hit");
    rd(3'd6, 32'hFFFF0FF0, "R11 status write wins");

    drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 1'b0, "R10 task switch");
    rd(3'd7, 32'hBD000420, "R10 locals cleared globals kept");
    exec(32'h1100, 1'b0, "R10 local slot0 now off");
    data(32'h3000, 2'd0, 1'b1, 1'b1, "R10 global slot2 still on");
    drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 3'd7, 32'hBD000441, 1'b0, "R11 ctrl write vs task switch");
    rd(3'd7, 32'hBD000441, "R11 control write wins");

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule